// File: doc/BRIEF.md
# Interrupt-Driven Single-Transfer Engine

This block lets an interrupt that has already won arbitration move one data item instead of starting a software service routine. Eight channels each hold a control word, a source pointer and a destination pointer. When the arbiter presents a granted request at level 14 or 15 for a channel whose count is nonzero, the engine reads one byte or one 16-bit word at the source pointer, writes it at the destination pointer, and then updates the count and the selected pointer. It then returns a one-cycle completion pulse so that the arbiter can clear the request flag.

A request below level 14, or a request for a channel whose count has reached zero, causes no memory cycle. The engine instead returns a one-cycle pulse that hands the event to the CPU as an ordinary interrupt. Software sets up the channels through a small register-write port. All addresses are 16 bits wide, so every transfer stays inside the first 64 KB segment.

Top module: `evxfer_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_req`, `evt_done` and `evt_irq` are all 0.
- R2: A request with level 14 or 15 on a channel whose count is nonzero produces one read cycle at the source pointer, then one write cycle at the destination pointer carrying the data that was read. The write cycle starts only after the read has completed.
- R3: A request with level below 14 produces no memory cycle. It produces a one-cycle `evt_irq` pulse with `evt_ch` equal to the requesting channel, and leaves the channel's count unchanged.
- R4: A request on a channel whose count is 0 produces no memory cycle and a one-cycle `evt_irq` pulse.
- R5: Bit 8 of the control word selects the transfer size: 1 for a 16-bit word and 0 for a byte. A word cycle drives `mem_be`=11. A byte cycle uses lane 0 (`mem_be`=01, data bits 7:0) at an even address and lane 1 (`mem_be`=10, data bits 15:8) at an odd address. A written byte is driven on both lanes.
- R6: Control bits 10:9 select which pointer advances after each transfer: 01 advances the destination, 10 advances the source, and 00 or 11 advance neither. The step is 1 for bytes and 2 for words.
- R7: Control bits 7:0 hold the count, which drops by one after every completed transfer. A count of 0xFF never decrements, so that channel keeps transferring.
- R8: A completed transfer gives exactly one cycle of `evt_done` with `evt_ch` equal to the channel. `evt_done` and `evt_irq` are never high together.
- R9: A register write (`cfg_sel` 0 = control, 1 = source, 2 = destination, 3 = none) to the channel whose transfer is in progress is ignored. Writes to other channels take effect during a transfer.
- R10: While `mem_req` is high and `mem_rdy` is low, the address, the write enable, the write data and the byte enables hold their values.
- R11: Each of the eight channels keeps its own count and pointers. Exhausting one channel does not affect another.
- R12: Pointer advance wraps modulo 64 KB, so a word source at 0xFFFE advances to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 3 | Channel being written |
| cfg_sel | input | 2 | 0 control, 1 source, 2 destination, 3 none |
| cfg_wdata | input | 16 | Register write data |
| req_valid | input | 1 | Granted request, held until a response pulse |
| req_ch | input | 3 | Channel of the request |
| req_lvl | input | 4 | Priority level of the request |
| evt_done | output | 1 | Transfer completed pulse |
| evt_irq | output | 1 | Hand event to CPU as an interrupt |
| evt_ch | output | 3 | Channel the pulse refers to |
| mem_req | output | 1 | Memory cycle active |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte lane enables |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory cycle completes this cycle |

## Verification
Some properties are checked on every cycle: the memory signals stay stable while the port stalls, the completion pulse lasts one cycle and never coincides with the CPU fallback, no memory cycle runs during a fallback, a write never starts before a read has completed, and a count of 0xFF holds. Each channel's registers are also checked to stay unchanged when software writes to a channel that is mid-transfer. Other behaviours need the bench's scenarios because they span several transfers: where byte data lands, how pointers step and wrap, that a count runs down to the CPU fallback, and that writes to a different channel during a transfer take effect.

// File: rtl/evxfer_pkg.sv
package evxfer_pkg;

  localparam int DW = 16;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;

  localparam logic [1:0] STEP_DST = 2'd1;
  localparam logic [1:0] STEP_SRC = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_POST = 2'd3
  } seq_st_e;

  function automatic logic [1:0] lane_be(input logic is_word, input logic odd);
    if (is_word) return 2'b11;
    return odd ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/evxfer_lane.sv
module evxfer_lane #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rd_data,
  input  logic          rd_odd,
  input  logic          wr_odd,
  input  logic          is_word,
  output logic [DW-1:0] wr_data
);
  localparam int BW = DW / 2;

  logic [BW-1:0] rd_byte;

  assign rd_byte = rd_odd ? rd_data[DW-1:BW] : rd_data[BW-1:0];

  // Bytes are replicated on both lanes; byte enables pick the live one.
  always_comb begin
    if (is_word) wr_data = rd_data;
    else         wr_data = {rd_byte, rd_byte};
  end

  logic unused_odd;
  assign unused_odd = wr_odd;

endmodule

// File: rtl/evxfer_chregs.sv
module evxfer_chregs
  import evxfer_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int AW    = 16,
  parameter int CNT_W = 8,
  parameter int CHW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [1:0]       cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             busy,
  input  logic [CHW-1:0]   act_ch,
  input  logic             upd,
  input  logic [CHW-1:0]   rd_ch,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_word,
  output logic [AW-1:0]    rd_src,
  output logic [AW-1:0]    rd_dst
);

  logic [CNT_W-1:0] cnt_q  [NCH];
  logic             word_q [NCH];
  logic [1:0]       mode_q [NCH];
  logic [AW-1:0]    src_q  [NCH];
  logic [AW-1:0]    dst_q  [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        cnt_q[i]  <= '0;
        word_q[i] <= 1'b0;
        mode_q[i] <= 2'b00;
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (upd && act_ch == CHW'(i)) begin
          if (cnt_q[i] != '1) cnt_q[i] <= cnt_q[i] - CNT_W'(1);
          if (mode_q[i] == STEP_SRC)
            src_q[i] <= src_q[i] + (word_q[i] ? AW'(2) : AW'(1));
          if (mode_q[i] == STEP_DST)
            dst_q[i] <= dst_q[i] + (word_q[i] ? AW'(2) : AW'(1));
        end else if (cfg_we && cfg_ch == CHW'(i) && !(busy && act_ch == CHW'(i))) begin
          case (cfg_sel)
            SEL_CTRL: begin
              cnt_q[i]  <= cfg_wdata[CNT_W-1:0];
              word_q[i] <= cfg_wdata[CNT_W];
              mode_q[i] <= cfg_wdata[CNT_W+2:CNT_W+1];
            end
            SEL_SRC: src_q[i] <= cfg_wdata[AW-1:0];
            SEL_DST: dst_q[i] <= cfg_wdata[AW-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_cnt  = cnt_q[rd_ch];
  assign rd_word = word_q[rd_ch];
  assign rd_src  = src_q[rd_ch];
  assign rd_dst  = dst_q[rd_ch];

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R7
    keep_ff_chk: assert property (@(posedge clk) disable iff (rst)
      (upd && act_ch == CHW'(g) && cnt_q[g] == '1) |=> cnt_q[g] == '1);
    // R7
    count_dec_chk: assert property (@(posedge clk) disable iff (rst)
      (upd && act_ch == CHW'(g) && cnt_q[g] != '1) |=> cnt_q[g] == $past(cnt_q[g]) - CNT_W'(1));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !upd && act_ch == CHW'(g) && cfg_we && cfg_ch == CHW'(g))
      |=> ($stable(cnt_q[g]) && $stable(src_q[g]) && $stable(dst_q[g])
           && $stable(mode_q[g]) && $stable(word_q[g])));
  end

endmodule

// File: rtl/evxfer_seq.sv
module evxfer_seq
  import evxfer_pkg::*;
#(
  parameter int AW      = 16,
  parameter int CNT_W   = 8,
  parameter int LVL_W   = 4,
  parameter int LVL_MIN = 14,
  parameter int CHW     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CHW-1:0]   req_ch,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic             rd_word,
  input  logic [AW-1:0]    rd_src,
  input  logic [AW-1:0]    rd_dst,
  input  logic [DW-1:0]    wr_data,
  output logic             is_word,
  output logic [AW-1:0]    dst_l,
  output logic             busy,
  output logic             upd,
  output logic [CHW-1:0]   act_ch,
  output logic             evt_done,
  output logic             evt_irq,
  output logic [CHW-1:0]   evt_ch,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [1:0]       mem_be,
  input  logic             mem_rdy
);

  seq_st_e st;
  logic    go;

  assign go   = (req_lvl >= LVL_W'(LVL_MIN)) && (rd_cnt != '0);
  assign busy = (st == ST_RD) || (st == ST_WR);
  assign upd  = (st == ST_WR) && mem_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      act_ch    <= '0;
      is_word   <= 1'b0;
      dst_l     <= '0;
      evt_done  <= 1'b0;
      evt_irq   <= 1'b0;
      evt_ch    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= 2'b00;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (go) begin
              act_ch   <= req_ch;
              is_word  <= rd_word;
              dst_l    <= rd_dst;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= rd_src;
              mem_be   <= lane_be(rd_word, rd_src[0]);
              st       <= ST_RD;
            end else begin
              evt_irq <= 1'b1;
              evt_ch  <= req_ch;
              st      <= ST_POST;
            end
          end
        end
        ST_RD: begin
          if (mem_rdy) begin
            mem_we    <= 1'b1;
            mem_addr  <= dst_l;
            mem_wdata <= wr_data;
            mem_be    <= lane_be(is_word, dst_l[0]);
            st        <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_rdy) begin
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            evt_done <= 1'b1;
            evt_ch   <= act_ch;
            st       <= ST_POST;
          end
        end
        default: begin
          evt_done <= 1'b0;
          evt_irq  <= 1'b0;
          st       <= ST_IDLE;
        end
      endcase
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_be)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    evt_done |=> !evt_done);
  // R8
  resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(evt_done && evt_irq));
  // R3
  irq_nomem_chk: assert property (@(posedge clk) disable iff (rst)
    evt_irq |-> !mem_req);
  // R2
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_req && mem_rdy));

endmodule

// File: rtl/evxfer_top.sv
module evxfer_top
  import evxfer_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int AW      = 16,
  parameter int CNT_W   = 8,
  parameter int LVL_W   = 4,
  parameter int LVL_MIN = 14,
  localparam int CHW    = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [1:0]       cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             req_valid,
  input  logic [CHW-1:0]   req_ch,
  input  logic [LVL_W-1:0] req_lvl,
  output logic             evt_done,
  output logic             evt_irq,
  output logic [CHW-1:0]   evt_ch,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [1:0]       mem_be,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_rdy
);

  logic [CNT_W-1:0] rd_cnt;
  logic             rd_word;
  logic [AW-1:0]    rd_src;
  logic [AW-1:0]    rd_dst;
  logic             busy;
  logic             upd;
  logic [CHW-1:0]   act_ch;
  logic             is_word;
  logic [AW-1:0]    dst_l;
  logic [DW-1:0]    wr_data;

  evxfer_chregs #(.NCH(NCH), .AW(AW), .CNT_W(CNT_W), .CHW(CHW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .act_ch(act_ch), .upd(upd),
    .rd_ch(req_ch), .rd_cnt(rd_cnt), .rd_word(rd_word),
    .rd_src(rd_src), .rd_dst(rd_dst)
  );

  evxfer_lane #(.DW(DW)) u_lane (
    .rd_data(mem_rdata), .rd_odd(mem_addr[0]), .wr_odd(dst_l[0]),
    .is_word(is_word), .wr_data(wr_data)
  );

  evxfer_seq #(.AW(AW), .CNT_W(CNT_W), .LVL_W(LVL_W), .LVL_MIN(LVL_MIN), .CHW(CHW)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ch(req_ch), .req_lvl(req_lvl),
    .rd_cnt(rd_cnt), .rd_word(rd_word), .rd_src(rd_src), .rd_dst(rd_dst),
    .wr_data(wr_data), .is_word(is_word), .dst_l(dst_l),
    .busy(busy), .upd(upd), .act_ch(act_ch),
    .evt_done(evt_done), .evt_irq(evt_irq), .evt_ch(evt_ch),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdy(mem_rdy)
  );

endmodule

// File: tb/sim_evxfer_top.sv
`timescale 1ns/1ps
module sim_evxfer_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_ch = '0;
  logic [3:0]  req_lvl = '0;
  logic        evt_done, evt_irq;
  logic [2:0]  evt_ch;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_be;
  logic        mem_rdy = 1'b0;

  always #2 clk = ~clk;

  evxfer_top u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ch(req_ch), .req_lvl(req_lvl),
    .evt_done(evt_done), .evt_irq(evt_irq), .evt_ch(evt_ch),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  // Memory model: 256 words, byte addressed.
  logic [15:0] mem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_idx = '0;
  logic [15:0] poke_val = '0;
  int          rd_n = 0, wr_n = 0;
  logic [15:0] last_rd = '0, last_wr = '0;
  logic [1:0]  last_be = '0;
  int          lat = 1;
  int          wcnt = 0;

  assign mem_rdata = mem[mem_addr[8:1]];

  always @(posedge clk) begin
    if (poke_en) mem[poke_idx] <= poke_val;
    if (mem_req && mem_rdy) begin
      if (!mem_we) begin
        rd_n <= rd_n + 1;
        last_rd <= mem_addr;
      end else begin
        wr_n <= wr_n + 1;
        last_wr <= mem_addr;
        last_be <= mem_be;
        if (mem_be[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
      end
    end
  end

  always @(negedge clk) begin
    if (!mem_req || mem_rdy) begin
      wcnt = 0;
      mem_rdy = 1'b0;
      if (mem_req && lat == 0) mem_rdy = 1'b1;
    end else begin
      wcnt = wcnt + 1;
      mem_rdy = (wcnt >= lat);
    end
  end

  int checks = 0, errors = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] idx, input logic [15:0] val);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = idx; poke_val = val;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] ch, input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [2:0] ch, input logic [15:0] ctrl,
                       input logic [15:0] src, input logic [15:0] dst);
    cfg(ch, 2'd0, ctrl);
    cfg(ch, 2'd1, src);
    cfg(ch, 2'd2, dst);
  endtask

  bit         got_done, got_irq;
  logic [2:0] got_ch;
  int         d_rd, d_wr;

  task automatic fire(input logic [2:0] ch, input logic [3:0] lvl);
    int r0, w0;
    r0 = rd_n; w0 = wr_n;
    @(negedge clk);
    req_valid = 1'b1; req_ch = ch; req_lvl = lvl;
    got_done = 0; got_irq = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (evt_done || evt_irq) begin
        got_done = evt_done; got_irq = evt_irq; got_ch = evt_ch;
        // R8: pulse must be gone one cycle later
        break;
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(!evt_done && !evt_irq, "R8 pulse one cycle", int'(evt_done), 0);
    d_rd = rd_n - r0; d_wr = wr_n - w0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !evt_done && !evt_irq, "R1 reset outputs", int'({mem_req, evt_done, evt_irq}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !evt_done && !evt_irq, "R1 after reset", int'({mem_req, evt_done, evt_irq}), 0);
  endtask

  task automatic t_word_count();
    lat = 1;
    poke(8'h10, 16'hBEEF);
    poke(8'h11, 16'hCAFE);
    setup(3'd0, 16'h0503, 16'h0020, 16'h0040);
    fire(3'd0, 4'd15);
    chk(got_done && got_ch == 3'd0, "R2 done on ch0", int'(got_ch), 0);
    chk(d_rd == 1 && d_wr == 1, "R2 one read one write", d_rd * 16 + d_wr, 17);
    chk(last_rd == 16'h0020 && last_wr == 16'h0040, "R2 addresses", int'(last_rd), 16'h20);
    chk(mem[8'h20] == 16'hBEEF, "R2 word data", int'(mem[8'h20]), 16'hBEEF);
    chk(last_be == 2'b11, "R5 word be", int'(last_be), 3);
    fire(3'd0, 4'd14);
    chk(last_rd == 16'h0022, "R6 src step 2", int'(last_rd), 16'h22);
    chk(last_wr == 16'h0040 && mem[8'h20] == 16'hCAFE, "R6 dst fixed", int'(mem[8'h20]), 16'hCAFE);
    fire(3'd0, 4'd15);
    chk(got_done, "R7 third transfer", int'(got_done), 1);
    fire(3'd0, 4'd15);
    chk(got_irq && !got_done && d_rd == 0 && d_wr == 0, "R4 zero count fallback", d_rd + d_wr, 0);
    chk(got_ch == 3'd0, "R4 fallback channel", int'(got_ch), 0);
  endtask

  task automatic t_low_level();
    setup(3'd1, 16'h0101, 16'h0030, 16'h0050);
    fire(3'd1, 4'd13);
    chk(got_irq && !got_done && got_ch == 3'd1, "R3 low level irq", int'(got_irq), 1);
    chk(d_rd == 0 && d_wr == 0, "R3 no memory cycle", d_rd + d_wr, 0);
    fire(3'd1, 4'd14);
    chk(got_done, "R3 count kept after low level", int'(got_done), 1);
    fire(3'd1, 4'd15);
    chk(got_irq, "R7 count of one runs out", int'(got_irq), 1);
  endtask

  task automatic t_byte();
    lat = 0;
    poke(8'h28, 16'h12A5);
    poke(8'h30, 16'hFF00);
    setup(3'd2, 16'h0204, 16'h0051, 16'h0060);
    fire(3'd2, 4'd15);
    chk(last_rd == 16'h0051, "R5 odd byte read", int'(last_rd), 16'h51);
    chk(last_be == 2'b01 && mem[8'h30] == 16'hFF12, "R5 byte to low lane", int'(mem[8'h30]), 16'hFF12);
    fire(3'd2, 4'd15);
    chk(last_rd == 16'h0051, "R6 src not advanced", int'(last_rd), 16'h51);
    chk(last_wr == 16'h0061 && last_be == 2'b10, "R6 dst step 1", int'(last_wr), 16'h61);
    chk(mem[8'h30] == 16'h1212, "R5 byte to high lane", int'(mem[8'h30]), 16'h1212);
  endtask

  task automatic t_endless();
    lat = 2;
    setup(3'd3, 16'h01FF, 16'h0024, 16'h0044);
    for (int n = 0; n < 5; n++) fire(3'd3, 4'd15);
    chk(got_done && got_ch == 3'd3, "R7 0xFF keeps transferring", int'(got_done), 1);
  endtask

  task automatic t_busy_write();
    lat = 6;
    setup(3'd4, 16'h0505, 16'h0080, 16'h00C0);
    setup(3'd5, 16'h0505, 16'h0010, 16'h00C4);
    fork
      fire(3'd4, 4'd15);
      begin
        repeat (2) @(negedge clk);
        cfg(3'd4, 2'd1, 16'h0090);
        cfg(3'd5, 2'd1, 16'h00A0);
      end
    join
    chk(got_done && last_rd == 16'h0080, "R9 first read", int'(last_rd), 16'h80);
    fire(3'd4, 4'd15);
    chk(last_rd == 16'h0082, "R9 write to active ch ignored", int'(last_rd), 16'h82);
    fire(3'd5, 4'd15);
    chk(last_rd == 16'h00A0, "R9 other ch write taken", int'(last_rd), 16'hA0);
    lat = 1;
    fire(3'd0, 4'd15);
    chk(got_irq, "R11 ch0 still exhausted", int'(got_irq), 1);
  endtask

  task automatic t_wrap();
    poke(8'hFF, 16'h1357);
    poke(8'h00, 16'h2468);
    setup(3'd6, 16'h0502, 16'hFFFE, 16'h0070);
    fire(3'd6, 4'd15);
    chk(last_rd == 16'hFFFE && mem[8'h38] == 16'h1357, "R12 top word", int'(mem[8'h38]), 16'h1357);
    fire(3'd6, 4'd15);
    chk(last_rd == 16'h0000 && mem[8'h38] == 16'h2468, "R12 wrap to zero", int'(last_rd), 0);
    setup(3'd7, 16'h0501, 16'h0000, 16'h0072);
    fire(3'd7, 4'd15);
    chk(got_done && got_ch == 3'd7, "R11 ch7 independent", int'(got_ch), 7);
  endtask

  initial begin
    t_reset();
    t_word_count();
    t_low_level();
    t_byte();
    t_endless();
    t_busy_write();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule